// File: doc/BRIEF.md
# Flash Erase-Geometry Query Table

This block answers identification queries for a parallel NOR flash bank whose erase map is split into up to four regions of differently sized sectors. A host presents a byte offset into the query table and receives the byte stored there one clock later. When several narrow devices sit side by side on one bank, every device lane of the data bus carries the same byte.

The table is not stored as constants. After reset, a small sequencer derives it from the region geometry and the number of interleaved devices. In the **SCAN** state it takes one region slot per cycle for four cycles. A slot counts only while no slot before it has had a zero sector count. For each counted slot it adds that slot's bytes to the bank total. In the **FILL** state it writes one table byte per cycle, 77 cycles in all, into a register file. It then enters **SERVE**, raises `ready` and stays there until the next reset. The transitions are: reset to SCAN; SCAN to FILL once the last slot has been taken; FILL to SERVE once the last table byte has been written. Entering and leaving query mode, and the storage array itself, belong to neighbouring logic.

Geometry parameters give each slot's sector count and its sector length in bank bytes (all devices together). Per-device lengths and sizes are the bank values divided by the device count, which must be a power of two.

Top module: `cfi_query_responder`

## Requirements
- R1: Offsets 0x10, 0x11 and 0x12 read as the ASCII bytes 0x51, 0x52, 0x59 ("QRY").
- R2: Offset 0x2C reads as the number of active regions. A region is active when its sector count is nonzero and every region slot below it is also nonzero, so a slot that follows a zero-count slot is ignored.
- R3: Active region k fills offsets 0x2D+4k to 0x30+4k. In that order they hold the low byte of (count−1), the high byte of (count−1), bits 15:8 of the per-device sector length and bits 23:16 of the per-device sector length.
- R4: Record offsets of inactive region slots (up to 0x3C) read as zero.
- R5: Offset 0x27 reads as log2 of the per-device total size. The per-device total is the sum over active regions of count × bank sector length, divided by the device count.
- R6: Offsets 0x15 and 0x16 read as 0x40 and 0x00, the pointer to the extended table.
- R7: Offsets 0x40 to 0x44 read as "PRI10" (0x50, 0x52, 0x49, 0x31, 0x30). Offsets 0x45 to 0x4C read as zero.
- R8: Every other offset up to 0x4C, and every offset above 0x4C, reads as zero.
- R9: The 8-bit result appears in every device lane: lane g is `rd_data[8g+7:8g]`.
- R10: `ready` is low while the table is being built, rises after 4 + 77 cycles and then stays high. A read is accepted only when `rd_en` and `ready` are both high at a clock edge. An accepted read gives `rd_valid` high with the byte on the next cycle. No other cycle gives `rd_valid` high, and `rd_data` is zero whenever `rd_valid` is low.
- R11: In reset, `ready`, `rd_valid` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Query read request |
| rd_offset | input | 8 | Query table offset |
| ready | output | 1 | Table built, reads accepted |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 8*NUM_DEV | Query byte copied into each device lane |

## Verification
On every cycle the bound checker enforces the read handshake timing, the zero data bus outside valid cycles, the fact that `ready` never falls once raised, lane replication, the signature bytes and zero data beyond the table. Only the bench's scenarios can show that the table content matches the geometry. That covers the region count stopping at a zero slot, the record byte layout, per-device scaling of lengths and total size, the unpopulated slots and the extended-table bytes. Two geometries are used for this: a two-device bank with four small-boot-sector regions and a single-device bank with a gap in its region list.

// File: rtl/cfi_geom_pkg.sv
package cfi_geom_pkg;

    // Four record slots are reserved so the extended table pointer stays fixed.
    localparam int REGION_SLOTS = 4;
    localparam int SLOT_W       = $clog2(REGION_SLOTS);
    localparam int NACT_W       = $clog2(REGION_SLOTS + 1);
    localparam int TABLE_BYTES  = 77;
    localparam int IDX_W        = $clog2(TABLE_BYTES);
    localparam int OFS_W        = 8;
    localparam int CNT_W        = 16;
    localparam int LEN_W        = 32;
    localparam int TOT_W        = CNT_W + LEN_W;
    localparam int TZ_W         = $clog2(TOT_W + 1);

    // Offsets whose position other logic decodes.
    localparam logic [IDX_W-1:0] IX_SIG_Q    = 7'h10;
    localparam logic [IDX_W-1:0] IX_SIG_R    = 7'h11;
    localparam logic [IDX_W-1:0] IX_SIG_Y    = 7'h12;
    localparam logic [IDX_W-1:0] IX_EXT_LO   = 7'h15;
    localparam logic [IDX_W-1:0] IX_EXT_HI   = 7'h16;
    localparam logic [IDX_W-1:0] IX_SIZE     = 7'h27;
    localparam logic [IDX_W-1:0] IX_NREG     = 7'h2C;
    localparam logic [IDX_W-1:0] IX_REC_BASE = 7'h2D;
    localparam logic [IDX_W-1:0] IX_REC_LAST = 7'h3C;
    localparam logic [IDX_W-1:0] IX_EXT_BASE = 7'h40;
    localparam logic [IDX_W-1:0] IX_EXT_LAST = 7'h44;

    localparam logic [7:0] EXT_PTR = 8'h40;

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_FILL  = 2'd1,
        ST_SERVE = 2'd2
    } build_state_e;

    // Position of the lowest set bit; zero for a zero input.
    function automatic logic [TZ_W-1:0] lowest_set(input logic [TOT_W-1:0] v);
        logic [TZ_W-1:0] r;
        r = '0;
        for (int i = TOT_W - 1; i >= 0; i--) begin
            if (v[i]) r = TZ_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cfi_geom_scan.sv
module cfi_geom_scan
    import cfi_geom_pkg::*;
#(
    parameter logic [REGION_SLOTS*CNT_W-1:0] BLK_COUNTS = '0,
    parameter logic [REGION_SLOTS*LEN_W-1:0] SECT_BYTES = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [SLOT_W-1:0] slot,
    output logic [NACT_W-1:0] n_active,
    output logic [TOT_W-1:0]  total
);

    logic              open_q;
    logic [CNT_W-1:0]  cur_cnt;
    logic [LEN_W-1:0]  cur_len;
    logic [TOT_W-1:0]  cur_bytes;

    always_comb begin
        cur_cnt   = BLK_COUNTS[int'(slot)*CNT_W +: CNT_W];
        cur_len   = SECT_BYTES[int'(slot)*LEN_W +: LEN_W];
        cur_bytes = TOT_W'(cur_cnt) * TOT_W'(cur_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q   <= 1'b1;
            n_active <= '0;
            total    <= '0;
        end else if (step) begin
            if (open_q && (cur_cnt != '0)) begin
                n_active <= n_active + 1'b1;
                total    <= total + cur_bytes;
            end else begin
                open_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfi_byte_gen.sv
module cfi_byte_gen
    import cfi_geom_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter logic [REGION_SLOTS*CNT_W-1:0] BLK_COUNTS = '0,
    parameter logic [REGION_SLOTS*LEN_W-1:0] SECT_BYTES = '0
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [NACT_W-1:0] n_active,
    input  logic [TOT_W-1:0]  total,
    output logic [7:0]        gen_byte
);

    localparam int DEV_SHIFT = $clog2(NUM_DEV);

    logic [3:0]        rec_rel;
    logic [SLOT_W-1:0] rec_slot;
    logic [1:0]        rec_field;
    logic [CNT_W-1:0]  cnt_m1;
    logic [7:0]        len_mid;
    logic [7:0]        len_top;
    logic [TZ_W-1:0]   tz;
    logic [7:0]        size_log2;
    logic              in_rec;
    logic              in_ext;

    always_comb begin
        rec_rel   = 4'(idx - IX_REC_BASE);
        rec_slot  = rec_rel[3:2];
        rec_field = rec_rel[1:0];
        cnt_m1    = BLK_COUNTS[int'(rec_slot)*CNT_W +: CNT_W] - 1'b1;
        len_mid   = SECT_BYTES[int'(rec_slot)*LEN_W + DEV_SHIFT + 8  +: 8];
        len_top   = SECT_BYTES[int'(rec_slot)*LEN_W + DEV_SHIFT + 16 +: 8];
        tz        = lowest_set(total);
        size_log2 = (int'(tz) >= DEV_SHIFT) ? (8'(tz) - 8'(DEV_SHIFT)) : 8'h00;
        in_rec    = (idx >= IX_REC_BASE) && (idx <= IX_REC_LAST);
        in_ext    = (idx >= IX_EXT_BASE) && (idx <= IX_EXT_LAST);
    end

    always_comb begin
        gen_byte = 8'h00;
        if (in_rec) begin
            if (NACT_W'(rec_slot) < n_active) begin
                unique case (rec_field)
                    2'd0: gen_byte = cnt_m1[7:0];
                    2'd1: gen_byte = cnt_m1[15:8];
                    2'd2: gen_byte = len_mid;
                    2'd3: gen_byte = len_top;
                endcase
            end
        end else if (in_ext) begin
            unique case (idx - IX_EXT_BASE)
                7'd0:    gen_byte = 8'h50;
                7'd1:    gen_byte = 8'h52;
                7'd2:    gen_byte = 8'h49;
                7'd3:    gen_byte = 8'h31;
                default: gen_byte = 8'h30;
            endcase
        end else begin
            case (idx)
                IX_SIG_Q:  gen_byte = 8'h51;
                IX_SIG_R:  gen_byte = 8'h52;
                IX_SIG_Y:  gen_byte = 8'h59;
                IX_EXT_LO: gen_byte = EXT_PTR;
                IX_EXT_HI: gen_byte = 8'h00;
                IX_SIZE:   gen_byte = size_log2;
                IX_NREG:   gen_byte = 8'(n_active);
                default:   gen_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/cfi_table_store.sv
module cfi_table_store
    import cfi_geom_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [7:0]         wbyte,
    input  logic               re,
    input  logic [OFS_W-1:0]   raddr,
    output logic               rvalid,
    output logic [8*LANES-1:0] rdata
);

    logic [7:0] cells [TABLE_BYTES];
    logic [7:0] rbyte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TABLE_BYTES; i++) cells[i] <= 8'h00;
        end else if (we) begin
            cells[widx] <= wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rbyte  <= 8'h00;
        end else if (re) begin
            rvalid <= 1'b1;
            rbyte  <= (raddr < OFS_W'(TABLE_BYTES)) ? cells[raddr[IDX_W-1:0]] : 8'h00;
        end else begin
            rvalid <= 1'b0;
            rbyte  <= 8'h00;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*8 +: 8] = rbyte;
    end

endmodule

// File: rtl/cfi_query_responder.sv
module cfi_query_responder
    import cfi_geom_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter logic [REGION_SLOTS*CNT_W-1:0] BLK_COUNTS =
        {16'd1, 16'd2, 16'd1, 16'd127},
    parameter logic [REGION_SLOTS*LEN_W-1:0] SECT_BYTES =
        {32'h0000_4000, 32'h0000_2000, 32'h0000_8000, 32'h0001_0000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [OFS_W-1:0]     rd_offset,
    output logic                 ready,
    output logic                 rd_valid,
    output logic [8*NUM_DEV-1:0] rd_data
);

    build_state_e      state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  fill_q;
    logic              scan_step;
    logic              fill_we;
    logic              read_go;
    logic [NACT_W-1:0] n_active;
    logic [TOT_W-1:0]  total;
    logic [7:0]        gen_byte;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // Build counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            fill_q <= '0;
        end else begin
            if (scan_step) slot_q <= slot_q + 1'b1;
            if (fill_we)   fill_q <= fill_q + 1'b1;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        scan_step = 1'b0;
        fill_we   = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                scan_step = 1'b1;
                if (slot_q == SLOT_W'(REGION_SLOTS - 1)) state_d = ST_FILL;
            end
            ST_FILL: begin
                fill_we = 1'b1;
                if (fill_q == IDX_W'(TABLE_BYTES - 1)) state_d = ST_SERVE;
            end
            ST_SERVE: begin
                ready = 1'b1;
            end
            default: state_d = ST_SCAN;
        endcase
    end

    assign read_go = rd_en && ready;

    cfi_geom_scan #(
        .BLK_COUNTS (BLK_COUNTS),
        .SECT_BYTES (SECT_BYTES)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (scan_step),
        .slot     (slot_q),
        .n_active (n_active),
        .total    (total)
    );

    cfi_byte_gen #(
        .NUM_DEV    (NUM_DEV),
        .BLK_COUNTS (BLK_COUNTS),
        .SECT_BYTES (SECT_BYTES)
    ) u_gen (
        .idx      (fill_q),
        .n_active (n_active),
        .total    (total),
        .gen_byte (gen_byte)
    );

    cfi_table_store #(
        .LANES (NUM_DEV)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (fill_we),
        .widx   (fill_q),
        .wbyte  (gen_byte),
        .re     (read_go),
        .raddr  (rd_offset),
        .rvalid (rd_valid),
        .rdata  (rd_data)
    );

endmodule

// File: rtl/cfi_query_checker.sv
module cfi_query_checker #(
    parameter int LANES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [7:0]         rd_offset,
    input logic               ready,
    input logic               rd_valid,
    input logic [8*LANES-1:0] rd_data
);

    assert_valid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready) |=> rd_valid);

    assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && ready) |=> !rd_valid);

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_past_end_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready && (rd_offset > 8'h4C)) |=> (rd_data == '0));

    assert_sig_q_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready && (rd_offset == 8'h10)) |=> (rd_data[7:0] == 8'h51));

    for (genvar g = 1; g < LANES; g++) begin : g_lane_chk
        assert_lane_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[g*8 +: 8] == rd_data[7:0]);
    end

endmodule

bind cfi_query_responder cfi_query_checker #(.LANES(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_offset (rd_offset),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/tb_cfi_query_responder.sv
`timescale 1ns/1ps
module tb_cfi_query_responder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bank A: two x8 devices, four regions.
    logic        en_a = 1'b0;
    logic [7:0]  ofs_a = 8'h00;
    logic        rdy_a, val_a;
    logic [15:0] dat_a;

    // Bank B: one device, gap after the second region.
    logic        en_b = 1'b0;
    logic [7:0]  ofs_b = 8'h00;
    logic        rdy_b, val_b;
    logic [7:0]  dat_b;

    cfi_query_responder #(
        .NUM_DEV    (2),
        .BLK_COUNTS ({16'd1, 16'd2, 16'd1, 16'd127}),
        .SECT_BYTES ({32'h0000_4000, 32'h0000_2000, 32'h0000_8000, 32'h0001_0000})
    ) dut (
        .clk(clk), .rst_n(rst_n), .rd_en(en_a), .rd_offset(ofs_a),
        .ready(rdy_a), .rd_valid(val_a), .rd_data(dat_a)
    );

    cfi_query_responder #(
        .NUM_DEV    (1),
        .BLK_COUNTS ({16'd5, 16'd0, 16'd3, 16'd8}),
        .SECT_BYTES ({32'h0000_4000, 32'h0000_0000, 32'h0001_0000, 32'h0000_2000})
    ) dut_b (
        .clk(clk), .rst_n(rst_n), .rd_en(en_b), .rd_offset(ofs_b),
        .ready(rdy_b), .rd_valid(val_b), .rd_data(dat_b)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic read_a(input logic [7:0] o, output logic [15:0] d, output logic v);
        @(negedge clk);
        en_a = 1'b1; ofs_a = o;
        @(negedge clk);
        en_a = 1'b0;
        d = dat_a; v = val_a;
    endtask

    task automatic read_b(input logic [7:0] o, output logic [7:0] d, output logic v);
        @(negedge clk);
        en_b = 1'b1; ofs_b = o;
        @(negedge clk);
        en_b = 1'b0;
        d = dat_b; v = val_b;
    endtask

    // Reads bank A and checks the byte in both lanes.
    task automatic expect_a(input string req, input logic [7:0] o, input logic [7:0] b);
        logic [15:0] d; logic v;
        read_a(o, d, v);
        check(req, $sformatf("A valid @%h", o), 32'(v), 32'd1);
        check(req, $sformatf("A data @%h", o), 32'(d), 32'({b, b}));
    endtask

    task automatic expect_b(input string req, input logic [7:0] o, input logic [7:0] b);
        logic [7:0] d; logic v;
        read_b(o, d, v);
        check(req, $sformatf("B valid @%h", o), 32'(v), 32'd1);
        check(req, $sformatf("B data @%h", o), 32'(d), 32'(b));
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R11", "ready in reset", 32'(rdy_a), 32'd0);
        check("R11", "valid in reset", 32'(val_a), 32'd0);
        check("R11", "data in reset", 32'(dat_a), 32'd0);
    endtask

    task automatic t_busy_read;
        logic [15:0] d; logic v;
        rst_n = 1'b1;
        read_a(8'h10, d, v);
        check("R10", "ready during build", 32'(rdy_a), 32'd0);
        check("R10", "busy read not valid", 32'(v), 32'd0);
        check("R10", "busy read data", 32'(d), 32'd0);
    endtask

    task automatic t_wait_ready;
        int n = 0;
        while (!(rdy_a && rdy_b) && n < 400) begin
            @(negedge clk);
            n++;
        end
        check("R10", "ready reached", 32'(rdy_a && rdy_b), 32'd1);
    endtask

    task automatic t_signature;
        expect_a("R1", 8'h10, 8'h51);
        expect_a("R1", 8'h11, 8'h52);
        expect_a("R1", 8'h12, 8'h59);
        expect_b("R1", 8'h12, 8'h59);
    endtask

    task automatic t_pointer;
        expect_a("R6", 8'h15, 8'h40);
        expect_a("R6", 8'h16, 8'h00);
    endtask

    task automatic t_geometry_a;
        logic [7:0] exp_rec [16];
        exp_rec = '{8'h7E, 8'h00, 8'h80, 8'h00,  8'h00, 8'h00, 8'h40, 8'h00,
                    8'h01, 8'h00, 8'h10, 8'h00,  8'h00, 8'h00, 8'h20, 8'h00};
        expect_a("R2", 8'h2C, 8'h04);
        for (int i = 0; i < 16; i++) expect_a("R3", 8'(8'h2D + i), exp_rec[i]);
        expect_a("R5", 8'h27, 8'h16);
    endtask

    task automatic t_geometry_b;
        logic [7:0] exp_rec [8];
        exp_rec = '{8'h07, 8'h00, 8'h20, 8'h00,  8'h02, 8'h00, 8'h00, 8'h01};
        expect_b("R2", 8'h2C, 8'h02);
        for (int i = 0; i < 8; i++) expect_b("R3", 8'(8'h2D + i), exp_rec[i]);
        for (int i = 8; i < 16; i++) expect_b("R4", 8'(8'h2D + i), 8'h00);
        expect_b("R5", 8'h27, 8'h12);
    endtask

    task automatic t_ext_table;
        expect_a("R7", 8'h40, 8'h50);
        expect_a("R7", 8'h41, 8'h52);
        expect_a("R7", 8'h42, 8'h49);
        expect_a("R7", 8'h43, 8'h31);
        expect_a("R7", 8'h44, 8'h30);
        for (int o = 8'h45; o <= 8'h4C; o++) expect_a("R7", 8'(o), 8'h00);
    endtask

    task automatic t_zero_fill;
        expect_a("R8", 8'h00, 8'h00);
        expect_a("R8", 8'h13, 8'h00);
        expect_a("R8", 8'h3D, 8'h00);
        expect_a("R8", 8'h3F, 8'h00);
        expect_a("R8", 8'h4D, 8'h00);
        expect_a("R8", 8'hFF, 8'h00);
        expect_b("R8", 8'h80, 8'h00);
    endtask

    task automatic t_lanes_and_idle;
        logic [15:0] d; logic v;
        read_a(8'h11, d, v);
        check("R9", "lane1 equals lane0", 32'(d[15:8]), 32'(d[7:0]));
        @(negedge clk);
        check("R10", "valid drops after read", 32'(val_a), 32'd0);
        check("R10", "data zero when idle", 32'(dat_a), 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_busy_read();
        t_wait_ready();
        t_signature();
        t_pointer();
        t_geometry_a();
        t_geometry_b();
        t_ext_table();
        t_zero_fill();
        t_lanes_and_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule